// File: doc/BRIEF.md
# Bipolar Line Decoder with Violation Check

This block turns a ternary line signal, already split by an external slicer into a positive-mark rail and a negative-mark rail, back into a single unipolar NRZ bit stream. It runs on its own decode clock. One symbol is taken per cycle in which `in_valid` is high. The line code is chosen by `code_sel`. For codes with zero substitution, the block recognises the substitution groups and removes them, so they come back out as runs of zeros.

Each decoded bit carries an error flag. The flag marks three cases:
- a bipolar violation that no substitution group accounts for;
- a symbol with both rails high;
- the first zero that pushes a run of line zeros past the limit of the selected code.

A fixed delay line of eight symbols gives every substitution group time to finish before its first symbol leaves. Every decoded bit and its flag therefore emerge eight accepted symbols after they entered.

The symbol stream has a valid strobe but no ready signal. A line cannot be paused, so the block applies no back-pressure: every accepted symbol produces exactly one output beat one cycle later, and the consumer must take every beat. A loopback select makes the decoder read the rails of the local encoder instead of the external rails.

Top module: `bipolar_rz_decoder`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, `out_valid` is 0. The first eight output beats after reset carry data 0 and error 0.
- R2: A cycle with `in_valid` high produces a cycle with `out_valid` high exactly one clock later, and a cycle with `in_valid` low produces none. Beat k carries the result for the symbol accepted k-8 (counting accepted symbols from 0 after reset). Gaps in `in_valid` do not alter this mapping.
- R3: Rail coding: positive rail alone is a positive mark, negative rail alone is a negative mark, and neither rail is a zero. In code 0 (AMI), correctly alternating marks decode to 1, zeros decode to 0, and the error flag stays 0.
- R4: A single-rail mark whose polarity equals that of the previous single-rail mark since reset is a violation. A violation that is not removed by a substitution group is output as data 1 with the error flag set.
- R5: A symbol with both rails high decodes as data 1 with the error flag set, and it does not change the remembered mark polarity.
- R6: With code 1 (B8ZS), the eight-symbol group zero, zero, zero, V, B, zero, V, B decodes as eight zeros with no error. Here V is a violation and B is a correctly alternating mark.
- R7: With code 2 (B6ZS), the six-symbol group zero, V, B, zero, V, B decodes as six zeros with no error.
- R8: With code 3 (HDB3), both zero, zero, zero, V and B, zero, zero, V decode as four zeros with no error.
- R9: Consecutive line zeros are counted, and any mark restarts the count. The limit is 15 for AMI, 8 for B8ZS, 6 for B6ZS and 4 for HDB3. The first zero beyond the limit is output with the error flag set, and further zeros in the same run are not flagged.
- R10: With `loop_en` high, the decoder takes its symbols from `enc_p`/`enc_n`, and the external rails have no effect on the output.
- R11: Code 0 (AMI) removes no groups: an eight-symbol pattern shaped like a B8ZS group decodes mark by mark, and its violations are flagged.
- R12: Groups are recognised in arrival order, one after another. Back-to-back groups each decode to zeros without error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Decode clock |
| rst_n | input | 1 | Active-low synchronous reset |
| code_sel | input | 2 | Line code: 0 AMI, 1 B8ZS, 2 B6ZS, 3 HDB3 |
| loop_en | input | 1 | 1 selects the encoder rails as decoder input |
| in_valid | input | 1 | A symbol is present on the selected rails this cycle |
| line_p | input | 1 | External positive-mark rail |
| line_n | input | 1 | External negative-mark rail |
| enc_p | input | 1 | Local encoder positive-mark rail (loopback) |
| enc_n | input | 1 | Local encoder negative-mark rail (loopback) |
| out_valid | output | 1 | Output beat present |
| out_data | output | 1 | Decoded NRZ bit |
| out_err | output | 1 | Error flag for this bit |

## Verification
The hardest situation to reach is a violation under a substituting code that must still be reported, because it sits next to marks that almost form a legal group. A second hard case is two groups that abut, where the second group's leading mark follows a violation that has just been removed. The stimulus builds these from short symbol strings in which each group is placed right after a mark of known polarity, followed by a lone repeated mark. A sequential reference model walks the same strings to predict every beat. Loopback runs with both external rails held high, so any leak of those rails shows up as error beats.

// File: rtl/bl_pkg.sv
package bl_pkg;

  typedef enum logic [1:0] {
    LC_AMI  = 2'd0,
    LC_B8ZS = 2'd1,
    LC_B6ZS = 2'd2,
    LC_HDB3 = 2'd3
  } line_code_e;

  // One received symbol after classification.
  typedef struct packed {
    logic mark;  // a pulse was present on at least one rail
    logic viol;  // single-rail mark with the same polarity as the last one
    logic flag;  // both rails high or zero-run overflow
  } slot_t;

  // Longest substitution group; sets the delay-line depth.
  localparam int unsigned WIN = 8;

endpackage

// File: rtl/bl_rail_classify.sv
module bl_rail_classify
  import bl_pkg::*;
#(
  parameter int unsigned ZR_AMI  = 15,
  parameter int unsigned ZR_B8ZS = 8,
  parameter int unsigned ZR_B6ZS = 6,
  parameter int unsigned ZR_HDB3 = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  line_code_e code,
  input  logic       sym_valid,
  input  logic       rail_p,
  input  logic       rail_n,
  output slot_t      cls
);

  localparam int unsigned ZR_M1  = (ZR_AMI > ZR_B8ZS) ? ZR_AMI : ZR_B8ZS;
  localparam int unsigned ZR_M2  = (ZR_B6ZS > ZR_HDB3) ? ZR_B6ZS : ZR_HDB3;
  localparam int unsigned ZR_MAX = (ZR_M1 > ZR_M2) ? ZR_M1 : ZR_M2;
  localparam int unsigned ZW     = $clog2(ZR_MAX + 2);

  logic          last_pos;
  logic          seen_mark;
  logic [ZW-1:0] zcnt;
  logic [ZW-1:0] lim;
  logic          single, both, any_mark, zr_hit;

  always_comb begin
    unique case (code)
      LC_AMI:  lim = ZW'(ZR_AMI);
      LC_B8ZS: lim = ZW'(ZR_B8ZS);
      LC_B6ZS: lim = ZW'(ZR_B6ZS);
      default: lim = ZW'(ZR_HDB3);
    endcase
  end

  assign single   = rail_p ^ rail_n;
  assign both     = rail_p & rail_n;
  assign any_mark = rail_p | rail_n;
  assign zr_hit   = ~any_mark & (zcnt == lim);

  always_comb begin
    cls.mark = any_mark;
    cls.viol = single & seen_mark & (rail_p == last_pos);
    cls.flag = both | zr_hit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_pos  <= 1'b0;
      seen_mark <= 1'b0;
      zcnt      <= '0;
    end else if (sym_valid) begin
      if (single) begin
        last_pos  <= rail_p;
        seen_mark <= 1'b1;
      end
      if (any_mark)         zcnt <= '0;
      else if (zcnt == lim) zcnt <= lim + 1'b1;
      else if (zcnt < lim)  zcnt <= zcnt + 1'b1;
    end
  end

  // R9: an overflow flag is raised once per run, not on the next zero too.
  p_zrun_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && zr_hit) |=> (!zr_hit || code != $past(code)));

endmodule

// File: rtl/bl_subst_window.sv
module bl_subst_window
  import bl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  line_code_e code,
  input  logic       sym_valid,
  input  slot_t      in_slot,
  output logic       out_valid,
  output logic       out_data,
  output logic       out_err
);

  slot_t          d  [WIN];
  slot_t          w  [WIN];
  slot_t          nw [WIN];
  logic [WIN-1:0] clr;
  logic           m8, m6, m4, any_match;

  function automatic logic is_z(slot_t s);
    return !s.mark;
  endfunction

  function automatic logic is_b(slot_t s);
    return s.mark && !s.viol && !s.flag;
  endfunction

  function automatic logic is_v(slot_t s);
    return s.mark && s.viol && !s.flag;
  endfunction

  // Window seen by the newest symbol: index 0 newest, WIN-1 oldest.
  always_comb begin
    w[0] = in_slot;
    for (int i = 1; i < WIN; i++) w[i] = d[i-1];
  end

  always_comb begin
    m8 = (code == LC_B8ZS) && is_z(w[7]) && is_z(w[6]) && is_z(w[5]) &&
         is_v(w[4]) && is_b(w[3]) && is_z(w[2]) && is_v(w[1]) && is_b(w[0]);
    m6 = (code == LC_B6ZS) && is_z(w[5]) && is_v(w[4]) && is_b(w[3]) &&
         is_z(w[2]) && is_v(w[1]) && is_b(w[0]);
    m4 = (code == LC_HDB3) && (is_z(w[3]) || is_b(w[3])) &&
         is_z(w[2]) && is_z(w[1]) && is_v(w[0]);
    any_match = m8 | m6 | m4;
    if (m8)      clr = 8'hFF;
    else if (m6) clr = 8'h3F;
    else if (m4) clr = 8'h0F;
    else         clr = '0;
  end

  for (genvar i = 0; i < WIN; i++) begin : g_clear
    always_comb begin
      nw[i].mark = w[i].mark & ~clr[i];
      nw[i].viol = w[i].viol & ~clr[i];
      nw[i].flag = w[i].flag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WIN; i++) d[i] <= '0;
      out_valid <= 1'b0;
      out_data  <= 1'b0;
      out_err   <= 1'b0;
    end else begin
      out_valid <= sym_valid;
      out_data  <= sym_valid & d[WIN-1].mark;
      out_err   <= sym_valid & (d[WIN-1].viol | d[WIN-1].flag);
      if (sym_valid) begin
        for (int i = 0; i < WIN; i++) d[i] <= nw[i];
      end
    end
  end

  // R12: a completed group leaves its newest slot holding no mark.
  p_match_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && any_match) |=> !d[0].mark);

  // R4: an unremoved violation leaving the line shows as a flagged one.
  p_viol_carried_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && d[WIN-1].viol) |=> (out_err && out_data));

endmodule

// File: rtl/bipolar_rz_decoder.sv
module bipolar_rz_decoder
  import bl_pkg::*;
#(
  parameter int unsigned ZR_AMI  = 15,
  parameter int unsigned ZR_B8ZS = 8,
  parameter int unsigned ZR_B6ZS = 6,
  parameter int unsigned ZR_HDB3 = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] code_sel,
  input  logic       loop_en,
  input  logic       in_valid,
  input  logic       line_p,
  input  logic       line_n,
  input  logic       enc_p,
  input  logic       enc_n,
  output logic       out_valid,
  output logic       out_data,
  output logic       out_err
);

  line_code_e code;
  logic       sel_p, sel_n;
  slot_t      cur_slot;

  assign code  = line_code_e'(code_sel);
  assign sel_p = loop_en ? enc_p : line_p;
  assign sel_n = loop_en ? enc_n : line_n;

  bl_rail_classify #(
    .ZR_AMI (ZR_AMI),
    .ZR_B8ZS(ZR_B8ZS),
    .ZR_B6ZS(ZR_B6ZS),
    .ZR_HDB3(ZR_HDB3)
  ) u_classify (
    .clk      (clk),
    .rst_n    (rst_n),
    .code     (code),
    .sym_valid(in_valid),
    .rail_p   (sel_p),
    .rail_n   (sel_n),
    .cls      (cur_slot)
  );

  bl_subst_window u_window (
    .clk      (clk),
    .rst_n    (rst_n),
    .code     (code),
    .sym_valid(in_valid),
    .in_slot  (cur_slot),
    .out_valid(out_valid),
    .out_data (out_data),
    .out_err  (out_err)
  );

  // R2: one output beat per accepted symbol, one cycle later.
  p_beat_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R2: no beat without an accepted symbol.
  p_no_extra_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R4: an error flag only travels with a beat.
  p_err_with_beat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> out_valid);

endmodule

// File: tb/bipolar_rz_decoder_tb.sv
module bipolar_rz_decoder_tb_top;

  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] code_sel = 2'd0;
  logic       loop_en = 1'b0;
  logic       in_valid = 1'b0;
  logic       line_p = 1'b0, line_n = 1'b0, enc_p = 1'b0, enc_n = 1'b0;
  logic       out_valid, out_data, out_err;

  int total = 0;
  int bad = 0;

  bit [1:0] exp_q[$];
  string    tag_q[$];
  bit       sp[$];
  bit       sn[$];
  bit       prev_v = 1'b0;
  bit       m_last_pos;
  bit       m_seen;

  always #(CLK_P/2) clk = ~clk;

  bipolar_rz_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .code_sel(code_sel), .loop_en(loop_en),
    .in_valid(in_valid), .line_p(line_p), .line_n(line_n),
    .enc_p(enc_p), .enc_n(enc_n),
    .out_valid(out_valid), .out_data(out_data), .out_err(out_err)
  );

  // Monitor: pops expected beats as the design produces them.
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_v = 1'b0;
    end else begin
      total++;
      if (out_valid !== prev_v) begin
        bad++;
        $display("FAIL R2: out_valid=%0b expected %0b", out_valid, prev_v);
      end
      if (out_valid === 1'b1) begin
        total++;
        if (exp_q.size() == 0) begin
          bad++;
          $display("FAIL R2: unexpected beat data=%0b err=%0b expected none",
                   out_data, out_err);
        end else begin
          bit [1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if ({out_data, out_err} !== e) begin
            bad++;
            $display("FAIL %s: got data=%0b err=%0b expected data=%0b err=%0b",
                     t, out_data, out_err, e[1], e[0]);
          end
        end
      end
      prev_v = in_valid;
    end
  end

  // Append symbols: '+' positive, '-' negative, '0' zero, 'X' both rails.
  task automatic put(input string s);
    for (int i = 0; i < s.len(); i++) begin
      sp.push_back(s[i] == "+" || s[i] == "X");
      sn.push_back(s[i] == "-" || s[i] == "X");
    end
  endtask

  task automatic put_zeros(input int k);
    for (int i = 0; i < k; i++) put("0");
  endtask

  // Reference model built from the requirements; pushes expected beats.
  task automatic model(input int code, input string tag);
    int  n;
    int  lim;
    int  cnt;
    bit  mk[];
    bit  vi[];
    bit  fl[];
    n = sp.size();
    mk = new[n];
    vi = new[n];
    fl = new[n];
    lim = (code == 0) ? 15 : (code == 1) ? 8 : (code == 2) ? 6 : 4;
    cnt = 0;
    m_seen = 1'b0;
    m_last_pos = 1'b0;
    for (int j = 0; j < n; j++) begin
      bit ok;
      mk[j] = sp[j] | sn[j];
      vi[j] = 1'b0;
      fl[j] = sp[j] & sn[j];
      if (sp[j] ^ sn[j]) begin
        vi[j] = m_seen && (sp[j] == m_last_pos);
        m_last_pos = sp[j];
        m_seen = 1'b1;
      end
      if (mk[j]) cnt = 0;
      else if (cnt == lim) begin fl[j] = 1'b1; cnt = lim + 1; end
      else if (cnt < lim) cnt++;
      // group recognition ending at j
      if (code == 1 && j >= 7) begin
        ok = !mk[j-7] && !mk[j-6] && !mk[j-5] &&
             (mk[j-4] && vi[j-4] && !fl[j-4]) && (mk[j-3] && !vi[j-3] && !fl[j-3]) &&
             !mk[j-2] && (mk[j-1] && vi[j-1] && !fl[j-1]) && (mk[j] && !vi[j] && !fl[j]);
        if (ok) for (int k = j-7; k <= j; k++) begin mk[k] = 0; vi[k] = 0; end
      end else if (code == 2 && j >= 5) begin
        ok = !mk[j-5] && (mk[j-4] && vi[j-4] && !fl[j-4]) &&
             (mk[j-3] && !vi[j-3] && !fl[j-3]) && !mk[j-2] &&
             (mk[j-1] && vi[j-1] && !fl[j-1]) && (mk[j] && !vi[j] && !fl[j]);
        if (ok) for (int k = j-5; k <= j; k++) begin mk[k] = 0; vi[k] = 0; end
      end else if (code == 3 && j >= 3) begin
        ok = (!mk[j-3] || (!vi[j-3] && !fl[j-3])) && !mk[j-2] && !mk[j-1] &&
             (mk[j] && vi[j] && !fl[j]);
        if (ok) for (int k = j-3; k <= j; k++) begin mk[k] = 0; vi[k] = 0; end
      end
    end
    for (int i = 0; i < 8; i++) begin
      exp_q.push_back(2'b00);
      tag_q.push_back("R1");
    end
    for (int j = 0; j < n; j++) begin
      exp_q.push_back({mk[j], vi[j] | fl[j]});
      tag_q.push_back(tag);
    end
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 1'b0;
    in_valid = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    total++;
    if (out_valid !== 1'b0) begin
      bad++;
      $display("FAIL R1: out_valid=%0b expected 0 after reset", out_valid);
    end
  endtask

  // Runs one segment: reset, predict, drive symbols plus padding, drain.
  task automatic run(input int code, input bit loop, input bit gaps, input string tag);
    bit pol;
    do_reset();
    code_sel = code[1:0];
    loop_en = loop;
    model(code, tag);
    pol = m_seen ? ~m_last_pos : 1'b1;
    for (int i = 0; i < 8; i++) begin
      sp.push_back(pol);
      sn.push_back(~pol);
      pol = ~pol;
    end
    for (int i = 0; i < sp.size(); i++) begin
      if (gaps && (i % 3 == 2)) begin
        @(posedge clk); #1;
        in_valid = 1'b0;
        line_p = 1'b1;
        line_n = 1'b0;
      end
      @(posedge clk); #1;
      in_valid = 1'b1;
      if (loop) begin
        enc_p = sp[i]; enc_n = sn[i];
        line_p = 1'b1; line_n = 1'b1;
      end else begin
        line_p = sp[i]; line_n = sn[i];
        enc_p = 1'b1; enc_n = 1'b1;
      end
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
    repeat (12) @(posedge clk);
    @(negedge clk);
    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R2: %0d beats missing, expected 0 left (%s)", exp_q.size(), tag);
    end
    exp_q.delete();
    tag_q.delete();
    sp.delete();
    sn.delete();
  endtask

  initial begin
    #(CLK_P * 200000);
    total++;
    bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R3: plain alternation in AMI
    put("+0-0+-+00-");
    run(0, 1'b0, 1'b0, "R3");
    // R4: repeated polarity in AMI is flagged but kept
    put("+-++0--+0-");
    run(0, 1'b0, 1'b0, "R4");
    // R5: both rails high, polarity untouched
    put("+X-X+0X-");
    run(0, 1'b0, 1'b0, "R5");
    // R6: two B8ZS groups, then an illegal repeat
    put("+000+-0-+-000-+0+-0--0+");
    run(1, 1'b0, 1'b0, "R6");
    // R7: two B6ZS groups, then an illegal repeat
    put("+0+-0-+-0-+0+-0--");
    run(2, 1'b0, 1'b0, "R7");
    // R8: both HDB3 forms, then an illegal repeat
    put("+000+-00-+0++");
    run(3, 1'b0, 1'b0, "R8");
    // R9: zero-run limits per code
    put("+"); put_zeros(20); put("-");
    run(0, 1'b0, 1'b0, "R9");
    put("+"); put_zeros(6); put("-"); put_zeros(4); put("+");
    run(3, 1'b0, 1'b0, "R9");
    put("+"); put_zeros(7); put("-"); put_zeros(6); put("+");
    run(2, 1'b0, 1'b0, "R9");
    put("+"); put_zeros(9); put("-"); put_zeros(8); put("+");
    run(1, 1'b0, 1'b0, "R9");
    // R10: loopback with external rails stuck both-high
    put("+000+-00-0+-0");
    run(3, 1'b1, 1'b0, "R10");
    // R11: AMI leaves a B8ZS-shaped group intact
    put("+000+-0-+-");
    run(0, 1'b0, 1'b0, "R11");
    // R12: back-to-back HDB3 groups
    put("+000+-00-+00+-00-+");
    run(3, 1'b0, 1'b0, "R12");
    // R2: gaps in the symbol strobe do not disturb decoding
    put("+000+-0-+0-+");
    run(1, 1'b0, 1'b1, "R2");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule